// File: doc/BRIEF.md
# Two-Speed Start-Up Clock Controller

This block decides which clock drives the system after a reset or after a wake from sleep. When fast start is enabled and the primary source is a crystal, the system runs at once from the always-running internal RC clock. Meanwhile an oscillator start-up timer counts edges of the primary clock. When that count completes, the block moves the system to the primary clock without a glitch and raises a status bit. If the primary is not a crystal, no settling wait is needed and the block goes straight to the primary. If fast start is disabled with a crystal primary, the system clock stays stopped until the primary is ready.

Firmware running from the internal clock during start-up may request sleep before the switch happens. The block then stops both clock enables and re-arms the start-up timer, so the next wake counts the full settling time again. The block also holds the internal-clock postscaler code. Reset clears this code, it follows the firmware's select input while code runs, and it is frozen while asleep.

The outputs are the two enables for an external pair of clock gates, the postscaler code and the status bit. The controller runs in the internal clock domain and the start-up timer runs in the primary domain. All signals that cross between the domains pass through synchronisers.

Top module: `twospeed_clkctl`

## Requirements
- R1: While `rst_n` is low, `int_clk_en_o`, `pri_clk_en_o`, `pri_active_o` and `int_div_o` are all 0.
- R2: After reset, neither clock enable rises while `pwrt_done_i` is 0.
- R3: The primary mode code is a crystal when bit 2 of `pri_mode_i` is 0 (codes 0 to 3). With `fast_start_en_i`=1 and a crystal mode, `int_clk_en_o` rises within a few internal cycles of `pwrt_done_i`, and `pri_active_o` stays 0.
- R4: In a crystal mode, `pri_clk_en_o` rises no sooner than `OST_CYCLES` primary edges after the start-up sequence begins, and no more than a few dozen edges later. Once the switch has settled, `pri_active_o` is 1 and `int_clk_en_o` is 0.
- R5: With `fast_start_en_i`=0 and a crystal mode, `int_clk_en_o` never rises during start-up. The system clock stays stopped until the primary is enabled.
- R6: For a non-crystal mode (bit 2 of `pri_mode_i` is 1), the primary is enabled within a few dozen primary edges, without the start-up wait and without ever enabling the internal clock.
- R7: `int_clk_en_o` and `pri_clk_en_o` are never 1 together. The internal enable is 0 whenever `pri_active_o` is 1.
- R8: `int_div_o` is 0 after reset. While the system is clocked, it follows `frq_sel_i` within a few internal cycles.
- R9: A `sleep_req_i` pulse during fast start drops both enables. While asleep, no switch to the primary happens and changes on `frq_sel_i` do not reach `int_div_o`. The code held from before sleep is present when the internal clock restarts on wake.
- R10: Every wake restarts the start-up count from zero, so the primary is enabled no sooner than `OST_CYCLES` primary edges after the `wake_i` pulse.
- R11: A `sleep_req_i` pulse while on the primary drops `pri_clk_en_o` and `pri_active_o`. The following wake (fast start enabled, crystal) restarts on the internal clock with `pri_active_o` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| int_clk | input | 1 | Internal RC clock, always running |
| pri_clk | input | 1 | Primary oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset (a reset event) |
| fast_start_en_i | input | 1 | Fast start enable configuration bit |
| pri_mode_i | input | 3 | Primary mode code; bit 2 = 0 means crystal |
| frq_sel_i | input | 3 | Internal-clock postscaler select from firmware |
| pwrt_done_i | input | 1 | Power-up timer finished |
| sleep_req_i | input | 1 | One-cycle sleep request (internal domain) |
| wake_i | input | 1 | One-cycle wake event (internal domain) |
| int_clk_en_o | output | 1 | Enable for the internal-clock gate |
| pri_clk_en_o | output | 1 | Enable for the primary-clock gate (primary domain) |
| int_div_o | output | 3 | Postscaler code applied to the internal clock |
| pri_active_o | output | 1 | 1 when the primary clock drives the system |

## Verification
The hardest situation to reach is a sleep that lands partway through the start-up count, followed by a wake. From the ports this looks the same as a sequence that was never interrupted, unless the bench measures how many primary edges pass after the wake. The stimulus enables fast start with a crystal mode. It waits until the internal enable is up and issues the sleep at a chosen or random point before the count can finish. It then holds the sleep longer than a full count and changes the postscaler select. Finally it wakes the block and counts primary edges from the wake until the primary enable rises. A timer that did not restart would switch early, and a stale select would show up at restart.

// File: rtl/tsc_pkg.sv
package tsc_pkg;

    localparam int MODE_W = 3;
    localparam int FRQ_W  = 3;

    typedef enum logic [2:0] {
        ST_PWRT   = 3'd0,
        ST_START  = 3'd1,
        ST_SWITCH = 3'd2,
        ST_PRI    = 3'd3,
        ST_SLEEP  = 3'd4,
        ST_WAKE   = 3'd5
    } tsc_state_e;

    typedef struct packed {
        tsc_state_e        st;
        logic              run;      // internal clock allowed
        logic              want_pri; // primary clock requested
        logic              ost_req;  // start-up timer armed
        logic              int_en;   // internal gate enable
        logic [FRQ_W-1:0]  div;      // postscaler code
    } ctrl_regs_t;

    // Crystal-type primary modes have bit 2 clear.
    function automatic logic mode_is_xtal(input logic [MODE_W-1:0] mode);
        return !mode[MODE_W-1];
    endfunction

endpackage

// File: rtl/tsc_sync.sv
module tsc_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    localparam int CHW = W * STAGES;

    logic [CHW-1:0] chain_d;
    logic [CHW-1:0] chain_q;

    always_comb begin
        chain_d          = chain_q << W;
        chain_d[W-1:0]   = d_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign q_o = chain_q[CHW-1 -: W];

endmodule

// File: rtl/tsc_pri_side.sv
module tsc_pri_side #(
    parameter int OST_CYCLES  = 1024,
    parameter int SYNC_STAGES = 2
) (
    input  logic pri_clk,
    input  logic rst_n,
    input  logic ost_req_i,
    input  logic want_pri_i,
    input  logic int_en_i,
    output logic ost_done_o,
    output logic ost_ack_o,
    output logic pri_en_o,
    output logic pri_busy_o
);
    localparam int CW = $clog2(OST_CYCLES);
    localparam logic [CW-1:0] LAST = CW'(OST_CYCLES - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          done;
        logic          ack;
        logic          en;
        logic          busy;
    } pri_regs_t;

    pri_regs_t cur_q, nxt_d;
    logic      req_s, want_s, int_s;

    tsc_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (pri_clk),
        .rst_n (rst_n),
        .d_i   ({ost_req_i, want_pri_i, int_en_i}),
        .q_o   ({req_s, want_s, int_s})
    );

    always_comb begin
        nxt_d      = cur_q;
        nxt_d.ack  = req_s;
        // break-before-make: primary gate opens only once internal gate is seen closed
        nxt_d.en   = want_s && !int_s;
        nxt_d.busy = want_s || cur_q.en;
        if (!req_s) begin
            nxt_d.cnt  = '0;
            nxt_d.done = 1'b0;
        end else if (!cur_q.done) begin
            if (cur_q.cnt == LAST) nxt_d.done = 1'b1;
            else                   nxt_d.cnt  = cur_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge pri_clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    assign ost_done_o = cur_q.done;
    assign ost_ack_o  = cur_q.ack;
    assign pri_en_o   = cur_q.en;
    assign pri_busy_o = cur_q.busy;

    // R4: ready is declared only with the full count behind it
    p_ost_len_r4: assert property (@(posedge pri_clk) disable iff (!rst_n)
        cur_q.done |-> (cur_q.cnt == LAST));

    // R10: a dropped request clears the timer on the following edge
    p_ost_rearm_r10: assert property (@(posedge pri_clk) disable iff (!rst_n)
        (!req_s) |=> (!cur_q.done && cur_q.cnt == '0));

endmodule

// File: rtl/tsc_ctrl.sv
module tsc_ctrl
    import tsc_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              int_clk,
    input  logic              rst_n,
    input  logic              fast_start_en_i,
    input  logic [MODE_W-1:0] pri_mode_i,
    input  logic [FRQ_W-1:0]  frq_sel_i,
    input  logic              pwrt_done_i,
    input  logic              sleep_req_i,
    input  logic              wake_i,
    input  logic              ost_done_i,
    input  logic              ost_ack_i,
    input  logic              pri_en_i,
    input  logic              pri_busy_i,
    output logic              int_en_o,
    output logic              want_pri_o,
    output logic              ost_req_o,
    output logic [FRQ_W-1:0]  int_div_o,
    output logic              pri_active_o
);
    ctrl_regs_t cur_q, nxt_d;
    logic       done_s, ack_s, pri_en_s, busy_s;
    logic       xtal, twospd;

    tsc_sync #(.W(4), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (int_clk),
        .rst_n (rst_n),
        .d_i   ({ost_done_i, ost_ack_i, pri_en_i, pri_busy_i}),
        .q_o   ({done_s, ack_s, pri_en_s, busy_s})
    );

    always_comb begin
        xtal   = mode_is_xtal(pri_mode_i);
        twospd = fast_start_en_i && xtal;

        nxt_d        = cur_q;
        // internal gate opens only after the primary side reports idle
        nxt_d.int_en = cur_q.run && !cur_q.want_pri && !busy_s;
        // postscaler code tracks firmware only while the system is clocked
        if (cur_q.int_en || pri_en_s) nxt_d.div = frq_sel_i;

        unique case (cur_q.st)
            ST_PWRT: begin
                if (pwrt_done_i) begin
                    nxt_d.st      = ST_START;
                    nxt_d.ost_req = 1'b1;
                    nxt_d.run     = twospd;
                end
            end
            ST_START: begin
                nxt_d.ost_req = 1'b1;
                nxt_d.run     = twospd;
                if (!xtal || done_s) begin
                    nxt_d.st       = ST_SWITCH;
                    nxt_d.run      = 1'b0;
                    nxt_d.want_pri = 1'b1;
                end else if (twospd && sleep_req_i) begin
                    nxt_d.st      = ST_SLEEP;
                    nxt_d.run     = 1'b0;
                    nxt_d.ost_req = 1'b0;
                end
            end
            ST_SWITCH: begin
                if (pri_en_s) nxt_d.st = ST_PRI;
            end
            ST_PRI: begin
                if (sleep_req_i) begin
                    nxt_d.st       = ST_SLEEP;
                    nxt_d.want_pri = 1'b0;
                    nxt_d.ost_req  = 1'b0;
                end
            end
            ST_SLEEP: begin
                if (wake_i) nxt_d.st = ST_WAKE;
            end
            ST_WAKE: begin
                // wait until the primary side has cleared its timer and gate
                if (!ack_s && !busy_s) begin
                    nxt_d.st      = ST_START;
                    nxt_d.ost_req = 1'b1;
                    nxt_d.run     = twospd;
                end
            end
            default: begin
                nxt_d = '0;
            end
        endcase
    end

    always_ff @(posedge int_clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    assign int_en_o     = cur_q.int_en;
    assign want_pri_o   = cur_q.want_pri;
    assign ost_req_o    = cur_q.ost_req;
    assign int_div_o    = cur_q.div;
    assign pri_active_o = pri_en_s;

    // R7: status of primary excludes the internal gate
    p_status_excl_r7: assert property (@(posedge int_clk) disable iff (!rst_n)
        pri_en_s |-> !cur_q.int_en);

    // R9: asleep means the internal gate is closed on the next edge
    p_sleep_stop_r9: assert property (@(posedge int_clk) disable iff (!rst_n)
        (cur_q.st == ST_SLEEP) |=> !cur_q.int_en);

    // R9: postscaler code frozen while no clock runs
    p_div_hold_r9: assert property (@(posedge int_clk) disable iff (!rst_n)
        (!cur_q.int_en && !pri_en_s) |=> $stable(cur_q.div));

    // R10: restart waits for the timer clear to be acknowledged
    p_wake_rearm_r10: assert property (@(posedge int_clk) disable iff (!rst_n)
        (cur_q.st == ST_WAKE && ack_s) |=> (cur_q.st == ST_WAKE));

    // R2: nothing runs before the power-up timer completes
    p_pwrt_hold_r2: assert property (@(posedge int_clk) disable iff (!rst_n)
        (cur_q.st == ST_PWRT) |=> (!cur_q.int_en && !cur_q.want_pri));

endmodule

// File: rtl/twospeed_clkctl.sv
module twospeed_clkctl
    import tsc_pkg::*;
#(
    parameter int OST_CYCLES  = 1024,
    parameter int SYNC_STAGES = 2
) (
    input  logic              int_clk,
    input  logic              pri_clk,
    input  logic              rst_n,
    input  logic              fast_start_en_i,
    input  logic [MODE_W-1:0] pri_mode_i,
    input  logic [FRQ_W-1:0]  frq_sel_i,
    input  logic              pwrt_done_i,
    input  logic              sleep_req_i,
    input  logic              wake_i,
    output logic              int_clk_en_o,
    output logic              pri_clk_en_o,
    output logic [FRQ_W-1:0]  int_div_o,
    output logic              pri_active_o
);
    logic ost_req, want_pri, int_en;
    logic ost_done, ost_ack, pri_en, pri_busy;

    tsc_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
        .int_clk         (int_clk),
        .rst_n           (rst_n),
        .fast_start_en_i (fast_start_en_i),
        .pri_mode_i      (pri_mode_i),
        .frq_sel_i       (frq_sel_i),
        .pwrt_done_i     (pwrt_done_i),
        .sleep_req_i     (sleep_req_i),
        .wake_i          (wake_i),
        .ost_done_i      (ost_done),
        .ost_ack_i       (ost_ack),
        .pri_en_i        (pri_en),
        .pri_busy_i      (pri_busy),
        .int_en_o        (int_en),
        .want_pri_o      (want_pri),
        .ost_req_o       (ost_req),
        .int_div_o       (int_div_o),
        .pri_active_o    (pri_active_o)
    );

    tsc_pri_side #(.OST_CYCLES(OST_CYCLES), .SYNC_STAGES(SYNC_STAGES)) u_pri (
        .pri_clk    (pri_clk),
        .rst_n      (rst_n),
        .ost_req_i  (ost_req),
        .want_pri_i (want_pri),
        .int_en_i   (int_en),
        .ost_done_o (ost_done),
        .ost_ack_o  (ost_ack),
        .pri_en_o   (pri_en),
        .pri_busy_o (pri_busy)
    );

    assign int_clk_en_o = int_en;
    assign pri_clk_en_o = pri_en;

    // R7: the two gate enables never overlap
    p_gate_excl_r7: assert property (@(posedge int_clk) disable iff (!rst_n)
        !(int_en && pri_en));

endmodule

// File: tb/twospeed_clkctl_tb.sv
module twospeed_clkctl_tb;
    localparam int OST = 1024;

    logic       int_clk = 1'b0;
    logic       pri_clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       fast_start_en = 1'b0;
    logic [2:0] pri_mode = 3'd0;
    logic [2:0] frq_sel = 3'd0;
    logic       pwrt_done = 1'b0;
    logic       sleep_req = 1'b0;
    logic       wake = 1'b0;
    logic       int_clk_en, pri_clk_en, pri_active;
    logic [2:0] int_div;

    int checks = 0;
    int fails = 0;
    int overlap = 0;
    bit seen_int = 0;
    bit finished = 0;
    int unsigned pri_edges = 0;

    always #5 int_clk = ~int_clk;   // 100 MHz nominal
    always #3 pri_clk = ~pri_clk;

    twospeed_clkctl #(.OST_CYCLES(OST)) u_dut (
        .int_clk         (int_clk),
        .pri_clk         (pri_clk),
        .rst_n           (rst_n),
        .fast_start_en_i (fast_start_en),
        .pri_mode_i      (pri_mode),
        .frq_sel_i       (frq_sel),
        .pwrt_done_i     (pwrt_done),
        .sleep_req_i     (sleep_req),
        .wake_i          (wake),
        .int_clk_en_o    (int_clk_en),
        .pri_clk_en_o    (pri_clk_en),
        .int_div_o       (int_div),
        .pri_active_o    (pri_active)
    );

    always @(posedge pri_clk) pri_edges <= pri_edges + 1;
    always @(negedge int_clk) begin
        if (int_clk_en && pri_clk_en) overlap <= overlap + 1;
        if (int_clk_en) seen_int <= 1'b1;
    end

    function automatic bit exp_xtal(input logic [2:0] m);
        return !m[2];
    endfunction
    function automatic bit exp_twospd(input bit en, input logic [2:0] m);
        return en && exp_xtal(m);
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge int_clk);
    endtask

    task automatic pulse_sleep();
        sleep_req = 1'b1; cyc(1); sleep_req = 1'b0;
    endtask
    task automatic pulse_wake();
        wake = 1'b1; cyc(1); wake = 1'b0;
    endtask

    task automatic wait_int(output bit ok);
        ok = 0;
        for (int i = 0; i < 40; i++) begin
            if (int_clk_en) begin ok = 1; break; end
            cyc(1);
        end
    endtask

    task automatic wait_pri(output bit ok);
        ok = 0;
        for (int i = 0; i < 3000; i++) begin
            if (pri_clk_en) begin ok = 1; break; end
            cyc(1);
        end
    endtask

    task automatic do_reset(input bit en, input logic [2:0] mode);
        @(negedge int_clk);
        rst_n = 1'b0; pwrt_done = 1'b0; sleep_req = 1'b0; wake = 1'b0;
        fast_start_en = en; pri_mode = mode; frq_sel = 3'd0;
        cyc(4);
        chk(!int_clk_en && !pri_clk_en && !pri_active && int_div == 3'd0, "R1",
            "outputs during reset", {int_clk_en, pri_clk_en, pri_active, int_div}, 0);
        rst_n = 1'b1;
        cyc(1);
    endtask

    // reset, power-up wait, then the whole start-up up to the primary switch
    task automatic start_run(input bit en, input logic [2:0] mode, input logic [2:0] frq);
        bit ok;
        int unsigned t0, el;
        do_reset(en, mode);
        cyc(20);
        chk(!int_clk_en && !pri_clk_en, "R2", "enables before power-up done",
            {int_clk_en, pri_clk_en}, 0);
        seen_int = 0;
        pwrt_done = 1'b1;
        t0 = pri_edges;
        if (exp_twospd(en, mode)) begin
            wait_int(ok);
            chk(ok, "R3", "internal enable after power-up", int'(ok), 1);
            chk(!pri_active, "R3", "status on internal", int'(pri_active), 0);
            chk(int_div == 3'd0, "R8", "postscaler base after reset", int'(int_div), 0);
            frq_sel = frq;
            cyc(4);
            chk(int_div == frq, "R8", "postscaler follows select", int'(int_div), int'(frq));
        end
        wait_pri(ok);
        el = pri_edges - t0;
        if (exp_xtal(mode)) begin
            chk(ok && el >= OST && el <= OST + 40, "R4", "primary edges before switch",
                int'(el), OST);
            if (!en) chk(!seen_int, "R5", "internal enable during stall", int'(seen_int), 0);
        end else begin
            chk(ok && el <= 30, "R6", "non-crystal switch edges", int'(el), 30);
            chk(!seen_int, "R6", "internal enable for non-crystal", int'(seen_int), 0);
        end
        cyc(6);
        chk(pri_active && !int_clk_en, "R4", "settled on primary",
            {pri_active, int_clk_en}, 2);
    endtask

    // fast start, sleep after d cycles on internal, wake, then full recount
    task automatic sleep_cycle(input int d, input logic [2:0] frq);
        bit ok;
        int unsigned t0, el;
        do_reset(1'b1, 3'd2);
        pwrt_done = 1'b1;
        wait_int(ok);
        frq_sel = frq;
        cyc(d);
        pulse_sleep();
        cyc(8);
        chk(!int_clk_en && !pri_clk_en, "R9", "enables dropped by sleep",
            {int_clk_en, pri_clk_en}, 0);
        frq_sel = ~frq;
        cyc(800);
        chk(!pri_clk_en && !pri_active, "R9", "no switch while asleep",
            {pri_clk_en, pri_active}, 0);
        chk(int_div == frq, "R9", "select ignored while asleep", int'(int_div), int'(frq));
        frq_sel = frq;
        pulse_wake();
        t0 = pri_edges;
        wait_int(ok);
        chk(ok && int_div == frq, "R9", "held code on wake", int'(int_div), int'(frq));
        wait_pri(ok);
        el = pri_edges - t0;
        chk(ok && el >= OST, "R10", "full recount after wake", int'(el), OST);
    endtask

    initial begin
        bit ok;
        int unsigned t0, el;
        void'($urandom(32'd20240611));
        // R1..R4, R8: fast start on each crystal code
        start_run(1'b1, 3'd0, 3'd3);
        start_run(1'b1, 3'd3, 3'd7);
        // R5: stall with fast start off
        start_run(1'b0, 3'd1, 3'd1);
        // R6: non-crystal codes
        start_run(1'b1, 3'd4, 3'd2);
        start_run(1'b0, 3'd7, 3'd2);
        // R9, R10: sleep early and late in the count
        sleep_cycle(5, 3'd5);
        sleep_cycle(400, 3'd6);
        // R11: sleep from the primary, wake restarts on internal
        start_run(1'b1, 3'd2, 3'd4);
        pulse_sleep();
        cyc(12);
        chk(!pri_clk_en && !int_clk_en, "R11", "primary dropped by sleep",
            {pri_clk_en, int_clk_en}, 0);
        chk(!pri_active, "R11", "status after sleep", int'(pri_active), 0);
        cyc(10);
        pulse_wake();
        t0 = pri_edges;
        wait_int(ok);
        chk(ok && !pri_active, "R11", "wake restarts on internal", {ok, pri_active}, 2);
        wait_pri(ok);
        el = pri_edges - t0;
        chk(ok && el >= OST, "R10", "recount after primary sleep", int'(el), OST);
        // random mix
        for (int it = 0; it < 8; it++) begin
            bit en = bit'($urandom_range(0, 1));
            logic [2:0] md = 3'($urandom_range(0, 7));
            logic [2:0] fq = 3'($urandom_range(1, 7));
            if (it % 3 == 2) sleep_cycle(int'($urandom_range(10, 450)), fq);
            else             start_run(en, md, fq);
        end
        // R1: reset in mid-run clears the postscaler code
        do_reset(1'b1, 3'd0);
        chk(overlap == 0, "R7", "cycles with both enables high", overlap, 0);
        finished = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #1500000;
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog (all requirements): actual=expired expected=completed");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule